// File: doc/BRIEF.md
# Host Packet to Register Bus Bridge

This bridge sits between a byte stream from a host (for example the receive side of a serial link) and a byte-wide register bus that serves a number of peripheral slots. The host sends command packets. The bridge turns each one into single-byte bus cycles on the addressed slot and returns a packet for every command. The host never needs a separate interrupt line. When no host packet is being handled, the bridge polls the slots in turn. A slot that reports pending data is read out and its data is sent up to the host unasked.

Every packet, in either direction, starts with a header of four bytes. The order is command, slot, register, count. Data bytes follow the header. Acknowledgements, read responses and unsolicited packets all use this one layout. Bit 7 of the command byte marks a packet as the bridge's answer to a host command.

Top module: `pkt_bridge_top`

## Requirements
- R1: The header is taken in the order command, slot, register, count. Command bit 0 selects write (1) or read (0), and bit 1 selects address increment (1) or a fixed address (0). With bit 1 set, data byte i uses register (start + i) modulo 256.
- R2: With command bit 1 clear, every data byte of the packet accesses the start register.
- R3: After its last bus write, a write packet is answered by a four-byte header. The header repeats the command with bit 7 set, the same slot, the start register and the unchanged count. It carries no data bytes.
- R4: A read packet is answered by a header (command with bit 7 set, slot, start register, count) followed by the count bytes that the bus reads return, in access order. The output byte is held stable while out_ready is low.
- R5: A count of zero causes no bus cycle. It still produces the four-byte acknowledgement or an empty read response.
- R6: A poll cycle starts only when the bridge is idle and no host byte is waiting. Poll cycles visit slots 0 to NUM_SLOTS-1 in round-robin order and wrap back to slot 0.
- R7: When a poll returns a non-zero value n, the bridge sends an unsolicited packet {0x02, slot, 0x00, n}. The value 0x02 has bit 7 clear. After the header come n bytes read from registers 0 upward of that slot.
- R8: Output packets never interleave. While an output byte is pending, host bytes are not accepted (in_ready low). A host packet that arrives during an unsolicited packet is processed after that packet ends.
- R9: At most one of the read, write and poll strobes is high at a time. A strobe holds its slot and address until bus_ack_i is seen, and it is low in the cycle after the acknowledge.
- R10: While reset is asserted, all strobes and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte available |
| in_data | input | 8 | Host byte |
| in_ready | output | 1 | Bridge accepts the host byte this cycle |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte to host |
| out_ready | input | 1 | Host side takes the output byte |
| bus_slot_o | output | 8 | Slot addressed by the current bus cycle |
| bus_addr_o | output | 8 | Register address |
| bus_wdata_o | output | 8 | Write data |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| bus_poll_o | output | 1 | Poll strobe |
| bus_rdata_i | input | 8 | Read data, or pending byte count on a poll |
| bus_ack_i | input | 1 | Slot acknowledge |

## Verification
The bench builds the bridge with NUM_SLOTS set to 3 instead of the default 4. This makes the round-robin pointer wrap at a value that is not a power of two, so the wrap comparison is exercised rather than a natural counter rollover. Three slots also keep the bench's peripheral model small while still allowing host traffic, slow acknowledges and output back-pressure to overlap with unsolicited packets from different slots.

// File: rtl/pkt_bridge_pkg.sv
package pkt_bridge_pkg;
  localparam int BYTE_W      = 8;
  localparam int CMD_WR_BIT  = 0;
  localparam int CMD_INC_BIT = 1;
  localparam int CMD_RSP_BIT = 7;
  localparam logic [BYTE_W-1:0] AUTOSEND_CMD = 8'h02;

  typedef enum logic [3:0] {
    ST_IDLE, ST_HDR, ST_WGET, ST_WBUS, ST_RBUS, ST_TXHDR, ST_TXDATA, ST_POLL
  } seq_state_t;
endpackage

// File: rtl/pb_rr_sched.sv
module pb_rr_sched #(
  parameter int NUM_SLOTS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv_i,
  output logic [7:0] slot_o
);
  localparam int PTR_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_SLOTS - 1);

  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv_i) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  generate
    if (PTR_W < 8) begin : g_pad
      assign slot_o = {{(8-PTR_W){1'b0}}, ptr};
    end else begin : g_full
      assign slot_o = ptr[7:0];
    end
  endgenerate
endmodule

// File: rtl/pb_seq.sv
module pb_seq
  import pkt_bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic [7:0] bus_slot_o,
  output logic [7:0] bus_addr_o,
  output logic [7:0] bus_wdata_o,
  output logic       bus_rd_o,
  output logic       bus_wr_o,
  output logic       bus_poll_o,
  input  logic [7:0] bus_rdata_i,
  input  logic       bus_ack_i,
  input  logic [7:0] poll_slot_i,
  output logic       poll_adv_o
);
  seq_state_t state;
  logic [7:0] hcmd, hslot, hreg, hcnt, addr, remain;
  logic [1:0] hidx, txidx;
  logic [7:0] nxt_addr;

  assign nxt_addr   = addr + {7'd0, hcmd[CMD_INC_BIT]};
  assign in_ready   = (state == ST_IDLE) || (state == ST_HDR) || (state == ST_WGET);
  assign poll_adv_o = (state == ST_POLL) && bus_ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      hcmd <= '0; hslot <= '0; hreg <= '0; hcnt <= '0;
      addr <= '0; remain <= '0; hidx <= '0; txidx <= '0;
      out_valid <= 1'b0; out_data <= '0;
      bus_slot_o <= '0; bus_addr_o <= '0; bus_wdata_o <= '0;
      bus_rd_o <= 1'b0; bus_wr_o <= 1'b0; bus_poll_o <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (in_valid) begin
            hcmd <= in_data;
            hidx <= 2'd1;
            state <= ST_HDR;
          end else begin
            bus_poll_o <= 1'b1;
            bus_slot_o <= poll_slot_i;
            bus_addr_o <= '0;
            state <= ST_POLL;
          end
        end
        ST_HDR: begin
          if (in_valid) begin
            hidx <= hidx + 2'd1;
            case (hidx)
              2'd1: hslot <= in_data;
              2'd2: hreg  <= in_data;
              default: begin
                hcnt   <= in_data;
                remain <= in_data;
                addr   <= hreg;
                if (hcmd[CMD_WR_BIT] && (in_data != 8'd0)) begin
                  state <= ST_WGET;
                end else begin
                  out_data  <= hcmd | (8'd1 << CMD_RSP_BIT);
                  out_valid <= 1'b1;
                  txidx     <= 2'd0;
                  state     <= ST_TXHDR;
                end
              end
            endcase
          end
        end
        ST_WGET: begin
          if (in_valid) begin
            bus_wdata_o <= in_data;
            bus_slot_o  <= hslot;
            bus_addr_o  <= addr;
            bus_wr_o    <= 1'b1;
            state       <= ST_WBUS;
          end
        end
        ST_WBUS: begin
          if (bus_ack_i) begin
            bus_wr_o <= 1'b0;
            remain   <= remain - 8'd1;
            addr     <= nxt_addr;
            if (remain == 8'd1) begin
              out_data  <= hcmd | (8'd1 << CMD_RSP_BIT);
              out_valid <= 1'b1;
              txidx     <= 2'd0;
              state     <= ST_TXHDR;
            end else begin
              state <= ST_WGET;
            end
          end
        end
        ST_TXHDR: begin
          if (out_ready) begin
            if (txidx == 2'd3) begin
              out_valid <= 1'b0;
              if (remain != 8'd0) begin
                bus_rd_o   <= 1'b1;
                bus_slot_o <= hslot;
                bus_addr_o <= addr;
                state      <= ST_RBUS;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              txidx <= txidx + 2'd1;
              case (txidx)
                2'd0:    out_data <= hslot;
                2'd1:    out_data <= hreg;
                default: out_data <= hcnt;
              endcase
            end
          end
        end
        ST_RBUS: begin
          if (bus_ack_i) begin
            bus_rd_o  <= 1'b0;
            out_data  <= bus_rdata_i;
            out_valid <= 1'b1;
            state     <= ST_TXDATA;
          end
        end
        ST_TXDATA: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            remain    <= remain - 8'd1;
            addr      <= nxt_addr;
            if (remain == 8'd1) begin
              state <= ST_IDLE;
            end else begin
              bus_rd_o   <= 1'b1;
              bus_addr_o <= nxt_addr;
              state      <= ST_RBUS;
            end
          end
        end
        ST_POLL: begin
          if (bus_ack_i) begin
            bus_poll_o <= 1'b0;
            if (bus_rdata_i != 8'd0) begin
              hcmd      <= AUTOSEND_CMD;
              hslot     <= bus_slot_o;
              hreg      <= '0;
              hcnt      <= bus_rdata_i;
              remain    <= bus_rdata_i;
              addr      <= '0;
              out_data  <= AUTOSEND_CMD;
              out_valid <= 1'b1;
              txidx     <= 2'd0;
              state     <= ST_TXHDR;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_bridge_top.sv
module pkt_bridge_top #(
  parameter int NUM_SLOTS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       out_valid,
  output logic [7:0] out_data,
  input  logic       out_ready,
  output logic [7:0] bus_slot_o,
  output logic [7:0] bus_addr_o,
  output logic [7:0] bus_wdata_o,
  output logic       bus_rd_o,
  output logic       bus_wr_o,
  output logic       bus_poll_o,
  input  logic [7:0] bus_rdata_i,
  input  logic       bus_ack_i
);
  logic [7:0] poll_slot;
  logic       poll_adv;

  pb_rr_sched #(.NUM_SLOTS(NUM_SLOTS)) sched_i (
    .clk(clk), .rst(rst), .adv_i(poll_adv), .slot_o(poll_slot)
  );

  pb_seq seq_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .bus_slot_o(bus_slot_o), .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o),
    .bus_rd_o(bus_rd_o), .bus_wr_o(bus_wr_o), .bus_poll_o(bus_poll_o),
    .bus_rdata_i(bus_rdata_i), .bus_ack_i(bus_ack_i),
    .poll_slot_i(poll_slot), .poll_adv_o(poll_adv)
  );
endmodule

// File: rtl/pkt_bridge_chk.sv
module pkt_bridge_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       bus_rd,
  input logic       bus_wr,
  input logic       bus_poll,
  input logic       bus_ack,
  input logic [7:0] bus_addr,
  input logic [7:0] bus_slot
);
  logic strobe;
  assign strobe = bus_rd | bus_wr | bus_poll;

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bus_rd, bus_wr, bus_poll})); // R9

  AST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
    strobe && !bus_ack |=> $stable({bus_rd, bus_wr, bus_poll}) && $stable(bus_addr) && $stable(bus_slot)); // R9

  AST_STROBE_DROP: assert property (@(posedge clk) disable iff (rst)
    strobe && bus_ack |=> !strobe); // R9

  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R4

  AST_NO_INPUT_WHILE_OUT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R8

  AST_POLL_WHEN_FREE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_poll) |-> !$past(in_valid)); // R6
endmodule

bind pkt_bridge_top pkt_bridge_chk chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .bus_rd(bus_rd_o), .bus_wr(bus_wr_o), .bus_poll(bus_poll_o),
  .bus_ack(bus_ack_i), .bus_addr(bus_addr_o), .bus_slot(bus_slot_o)
);

// File: tb/pkt_bridge_top_tb_top.sv
module pkt_bridge_top_tb_top;
  localparam int NS = 3;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid;
  logic [7:0] out_data;
  logic out_ready = 1'b1;
  logic [7:0] bus_slot, bus_addr, bus_wdata, bus_rdata;
  logic bus_rd, bus_wr, bus_poll, bus_ack;
  logic ack_gate = 1'b1;

  always #4 clk = ~clk;

  logic [7:0] pmem [NS][256];
  logic [7:0] emem [NS][256];
  logic [7:0] pollcnt [NS];
  logic [7:0] pay [16];
  logic [7:0] out_q [$];
  logic [25:0] op_q [$];

  int checks = 0, fails = 0, cyc = 0;
  bit bp = 0, stall = 0, clr_pend = 0, have_prev = 0;
  int clr_slot = 0, prev_slot = 0;

  function automatic int sidx(input logic [7:0] s);
    return (int'(s) < NS) ? int'(s) : 0;
  endfunction

  assign bus_ack   = (bus_rd | bus_wr | bus_poll) & ack_gate;
  assign bus_rdata = bus_poll ? pollcnt[sidx(bus_slot)] : pmem[sidx(bus_slot)][bus_addr];

  pkt_bridge_top #(.NUM_SLOTS(NS)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .bus_slot_o(bus_slot), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .bus_poll_o(bus_poll),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // Reference model: peripherals, expected streams, compared every cycle
  always @(negedge clk) begin
    logic acc;
    logic [25:0] e, a;
    logic [7:0] eb;
    cyc++;
    out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
    ack_gate  = stall ? ((cyc % 4) != 2) : 1'b1;
    if (clr_pend) begin pollcnt[clr_slot] = 8'd0; clr_pend = 0; end
    if (!rst) begin
      acc = (bus_rd | bus_wr | bus_poll) & ack_gate;
      if (acc && bus_poll) begin
        if (have_prev) // R6 round-robin order
          check(int'(bus_slot) == (prev_slot + 1) % NS, "R6 poll slot", bus_slot, (prev_slot + 1) % NS);
        have_prev = 1; prev_slot = int'(bus_slot);
        if (pollcnt[sidx(bus_slot)] != 0) begin clr_pend = 1; clr_slot = sidx(bus_slot); end
      end
      if (acc && (bus_rd | bus_wr)) begin // R1 R2 R5: expected bus cycles only
        a = {bus_wr ? 2'd1 : 2'd2, bus_slot, bus_addr, bus_wr ? bus_wdata : 8'h00};
        if (op_q.size() == 0) check(0, "R5 unexpected bus cycle", a, 0);
        else begin
          e = op_q.pop_front();
          check(a == e, e[25:24] == 2'd1 ? "R1 R2 bus write" : "R1 R2 bus read", a, e);
        end
        if (bus_wr) pmem[sidx(bus_slot)][bus_addr] = bus_wdata;
      end
      if (out_valid && out_ready) begin // R3 R4 R7 output stream
        if (out_q.size() == 0) check(0, "R8 unexpected output byte", out_data, 0);
        else begin
          eb = out_q.pop_front();
          check(out_data == eb, "R3 R4 R7 output byte", out_data, eb);
        end
      end
      if (out_valid) check(!in_ready, "R8 input held off during output", in_ready, 0);
    end
    if (cyc > WATCHDOG) begin
      check(0, "watchdog", cyc, WATCHDOG);
      finish_run();
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic host_pkt(input logic [7:0] cmd, input int s, input logic [7:0] r, input int n);
    logic [7:0] a;
    a = r;
    out_q.push_back(cmd | 8'h80); out_q.push_back(8'(s));
    out_q.push_back(r); out_q.push_back(8'(n));
    for (int i = 0; i < n; i++) begin
      if (cmd[0]) begin
        op_q.push_back({2'd1, 8'(s), a, pay[i]});
        emem[s][a] = pay[i];
      end else begin
        op_q.push_back({2'd2, 8'(s), a, 8'h00});
        out_q.push_back(emem[s][a]);
      end
      if (cmd[1]) a = a + 8'd1;
    end
    send_byte(cmd); send_byte(8'(s)); send_byte(r); send_byte(8'(n));
    if (cmd[0]) for (int i = 0; i < n; i++) send_byte(pay[i]);
    @(negedge clk); in_valid = 1'b0;
  endtask

  task automatic arm_poll(input int s, input int n); // R7 expected autosend
    out_q.push_back(8'h02); out_q.push_back(8'(s));
    out_q.push_back(8'h00); out_q.push_back(8'(n));
    for (int i = 0; i < n; i++) begin
      op_q.push_back({2'd2, 8'(s), 8'(i), 8'h00});
      out_q.push_back(emem[s][i]);
    end
    @(negedge clk); pollcnt[s] = 8'(n);
  endtask

  task automatic wait_done();
    while (out_q.size() != 0 || op_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    for (int s = 0; s < NS; s++) begin
      pollcnt[s] = 8'd0;
      for (int a = 0; a < 256; a++) begin
        pmem[s][a] = 8'((s * 37 + a * 5) ^ 8'h5A);
        emem[s][a] = pmem[s][a];
      end
    end
    for (int i = 0; i < 16; i++) pay[i] = 8'(8'hA0 + i * 3);
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!bus_rd && !bus_wr && !bus_poll, "R10 strobes in reset", {bus_rd, bus_wr, bus_poll}, 0);
    check(!out_valid, "R10 out_valid in reset", out_valid, 0);
    rst = 1'b0;
    repeat (20) @(negedge clk);

    host_pkt(8'h03, 1, 8'h10, 3);  wait_done(); // R1 R3 write, increment
    host_pkt(8'h02, 1, 8'h10, 3);  wait_done(); // R4 read back
    host_pkt(8'h01, 2, 8'h20, 4);  wait_done(); // R2 fixed-address write
    host_pkt(8'h00, 2, 8'h20, 2);  wait_done(); // R2 R4 fixed-address read
    host_pkt(8'h03, 0, 8'h40, 0);  wait_done(); // R5 empty write
    host_pkt(8'h02, 0, 8'h40, 0);  wait_done(); // R5 empty read
    host_pkt(8'h03, 1, 8'hFE, 3);  wait_done(); // R1 address wrap
    host_pkt(8'h02, 1, 8'hFE, 3);  wait_done(); // R1 R4 wrap read
    arm_poll(0, 3);                wait_done(); // R7 autosend slot 0
    arm_poll(2, 2);                wait_done(); // R7 autosend slot 2

    bp = 1; stall = 1;
    host_pkt(8'h03, 2, 8'h05, 5);  wait_done(); // R1 R3 R9 slow bus
    host_pkt(8'h02, 2, 8'h05, 5);  wait_done(); // R4 back-pressure
    arm_poll(1, 4);                             // R8 host packet during autosend
    while (!out_valid) @(negedge clk);
    host_pkt(8'h02, 0, 8'h07, 2);  wait_done();
    arm_poll(2, 1);
    while (!out_valid) @(negedge clk);
    host_pkt(8'h01, 1, 8'h33, 3);  wait_done(); // R2 R8 write behind autosend
    finish_run();
  end
endmodule